// File: doc/BRIEF.md
# Serial port register and interrupt front end

This block is the register face of a simple serial port. A processor reaches it through a 32-bit bus with separate read and write strobes and a byte offset. It stores the settings for the transmitter, the receiver and interrupt masking. Bytes written to one offset are handed to the transmitter as one-cycle pulses. Bytes arriving from the receiver are taken through a valid/ready handshake and show up in a status word.

The status word can be read at two offsets. One read clears the data-available flag and the other leaves it alone, so software can poll without consuming the flag. Each transmit write raises a raw interrupt bit, and so does each received byte. Software clears raw bits by writing ones to an acknowledge offset. The masked vector, and the single level interrupt output, follow from raw AND mask one cycle after the event that changed them. Bit-level serialisation, baud timing and DMA are not part of this block.

Top module: `serial_regs`

## Requirements
- R1: After reset, the status word at offsets 0x20 and 0x24 reads 0x0140_0000, with only transmitter-idle (bit 22) and transmitter-ready (bit 24) set. Every other register reads zero, irq is 0, tx_valid is 0 and rx_ready is 1.
- R2: A write to transmit control (0x00), DMA enable (0x04), receive control (0x08) or interrupt mask (0x2C) stores all 32 bits, and reading the same offset returns them. bus_rdata is combinational from bus_addr and is sampled while bus_rd is high.
- R3: A write to offset 0x1C produces tx_valid high for exactly the next cycle, with tx_data equal to bus_wdata[7:0]. The same write sets raw interrupt bit 0.
- R4: When rx_valid and rx_ready are both high at a clock edge, the byte is stored in status bits 7:0, data-available (bit 16) is set and raw interrupt bit 3 is set.
- R5: rx_ready is high when receive control bit 0 is 1 or when raw interrupt bit 3 is 0. Otherwise it is low, and rx_valid then has no effect.
- R6: A read at offset 0x20 returns the status word and clears bit 16 after that cycle, unless a byte is accepted in the same cycle. A read at 0x24 returns the same word and changes nothing.
- R7: A write to offset 0x30 clears every raw interrupt bit (read at 0x34) whose position is 1 in bus_wdata. Events that occur in the same cycle set their bits after the clear. The acknowledge offset always reads zero.
- R8: Offset 0x38 reads raw AND mask. irq is 1 exactly when that value is nonzero, and it is registered, so it changes on the edge that ends the causing write or receive cycle.
- R9: Writes to unmapped offsets and to the read-only offsets 0x20, 0x24, 0x34 and 0x38 change no state. Reads from unmapped offsets, including 0x3C and misaligned offsets, return zero.
- R10: Status bits 22 and 24 read as 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers read side effect at 0x20) |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block can accept a receive byte |
| irq | output | 1 | Level interrupt, OR of masked vector |

## Verification
The assertions check on every cycle the following. The masked vector stays equal to raw AND mask, and irq agrees with it. rx_ready drops only while raw bit 3 is set. A transmit write yields its pulse and raw bit 0 on the next cycle. An accepted byte sets data-available and raw bit 3. A clearing read drops data-available, and an acknowledge leaves no acknowledged bit set. Other behaviours can only be shown by the bench's scenarios, which compare read data against a model. These are the exact read-back of every offset, zero for unmapped and misaligned offsets, writes to read-only offsets having no effect, and the interplay of an acknowledge and a receive in the same cycle.

// File: rtl/serial_regs.sv
module serial_regs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_TXC  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_RXC  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_STC  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_STP  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h2C);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'('h38);
  localparam int B_DAV  = 16;
  localparam int B_IDLE = 22;
  localparam int B_RDY  = 24;
  localparam int B_TXI  = 0;
  localparam int B_RXI  = 3;

  logic [31:0] txc_q, dma_q, rxc_q, mask_q, raw_q, masked_q;
  logic [7:0]  din_q;
  logic        dav_q;
  logic [31:0] stat_w, raw_nx, mask_nx, set_bits, ack_bits;
  logic        rx_fire, wr_dout;

  assign rx_ready = rxc_q[0] | ~raw_q[B_RXI];
  assign rx_fire  = rx_valid & rx_ready;
  assign wr_dout  = bus_wr && bus_addr == A_DOUT;

  always_comb begin
    stat_w = '0;
    stat_w[7:0]   = din_q;
    stat_w[B_DAV] = dav_q;
    stat_w[B_IDLE] = 1'b1;
    stat_w[B_RDY]  = 1'b1;
    set_bits = '0;
    set_bits[B_TXI] = wr_dout;
    set_bits[B_RXI] = rx_fire;
  end

  assign ack_bits = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;
  assign raw_nx   = (raw_q & ~ack_bits) | set_bits;
  assign mask_nx  = (bus_wr && bus_addr == A_MASK) ? bus_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txc_q    <= '0;
      dma_q    <= '0;
      rxc_q    <= '0;
      mask_q   <= '0;
      raw_q    <= '0;
      masked_q <= '0;
      din_q    <= '0;
      dav_q    <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      irq      <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_TXC: txc_q <= bus_wdata;
          A_DMA: dma_q <= bus_wdata;
          A_RXC: rxc_q <= bus_wdata;
          default: ;
        endcase
      end
      mask_q   <= mask_nx;
      raw_q    <= raw_nx;
      masked_q <= raw_nx & mask_nx;
      irq      <= |(raw_nx & mask_nx);
      tx_valid <= wr_dout;
      if (wr_dout) tx_data <= bus_wdata[7:0];
      if (rx_fire) begin
        din_q <= rx_data;
        dav_q <= 1'b1;
      end else if (bus_rd && bus_addr == A_STC) begin
        dav_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_TXC:        bus_rdata = txc_q;
      A_DMA:        bus_rdata = dma_q;
      A_RXC:        bus_rdata = rxc_q;
      A_STC, A_STP: bus_rdata = stat_w;
      A_MASK:       bus_rdata = mask_q;
      A_RAW:        bus_rdata = raw_q;
      A_MSKD:       bus_rdata = masked_q;
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/serial_regs_chk.sv
module serial_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [31:0]       raw_q,
  input logic [31:0]       mask_q,
  input logic [31:0]       masked_q,
  input logic              dav_q
);
  localparam logic [ADDR_W-1:0] C_DOUT = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] C_STC  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] C_ACK  = ADDR_W'('h30);

  a_r3_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_DOUT) |=> (tx_valid && tx_data == $past(bus_wdata[7:0]) && raw_q[0]));
  a_r3_tx_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr && bus_addr == C_DOUT));
  a_r4_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (dav_q && raw_q[3]));
  a_r5_ready_low_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> raw_q[3]);
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == C_STC && !(rx_valid && rx_ready)) |=> !dav_q);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_ACK && !(rx_valid && rx_ready)) |=> ((raw_q & $past(bus_wdata)) == 32'd0));
  a_r8_masked_vec: assert property (@(posedge clk) disable iff (!rst_n)
    masked_q == (raw_q & mask_q));
  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|masked_q));
endmodule

bind serial_regs serial_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_valid(tx_valid),
  .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq),
  .raw_q(raw_q), .mask_q(mask_q), .masked_q(masked_q), .dav_q(dav_q)
);

// File: tb/tb_serial_regs.sv
module tb_serial_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, rx_valid = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] rx_data = '0, tx_data;
  logic tx_valid, rx_ready, irq;

  serial_regs #(.ADDR_W(6)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_txc, m_dma, m_rxc, m_mask, m_raw;
  logic [7:0] m_din, m_txd;
  logic m_dav, m_txv, m_irq;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] stat_of();
    logic [31:0] s = 32'h0140_0000;
    s[7:0] = m_din;
    s[16] = m_dav;
    return s;
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a);
    case (a)
      6'h00: return m_txc;
      6'h04: return m_dma;
      6'h08: return m_rxc;
      6'h20, 6'h24: return stat_of();
      6'h2C: return m_mask;
      6'h34: return m_raw;
      6'h38: return m_raw & m_mask;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00, 6'h04, 6'h08, 6'h2C: return "R2";
      6'h20, 6'h24: return "R6";
      6'h30, 6'h34: return "R7";
      6'h38: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_txc = 0; m_dma = 0; m_rxc = 0; m_mask = 0; m_raw = 0;
    m_din = 0; m_dav = 0; m_txv = 0; m_txd = 0; m_irq = 0;
  endtask

  task automatic step(input bit we, input bit re, input logic [5:0] a, input logic [31:0] wd,
                      input bit rv, input logic [7:0] rd);
    bit rdy, fire;
    logic [31:0] ack;
    @(negedge clk);
    chk(tx_valid == m_txv, "R3", 32'(tx_valid), 32'(m_txv));
    if (m_txv) chk(tx_data == m_txd, "R3", 32'(tx_data), 32'(m_txd));
    chk(irq == m_irq, "R8", 32'(irq), 32'(m_irq));
    rdy = m_rxc[0] | ~m_raw[3];
    chk(rx_ready == rdy, "R5", 32'(rx_ready), 32'(rdy));
    bus_wr = we; bus_rd = re; bus_addr = a; bus_wdata = wd; rx_valid = rv; rx_data = rd;
    #1;
    if (re) chk(bus_rdata == model_read(a), tag_of(a), bus_rdata, model_read(a));
    @(posedge clk);
    fire = rv && rdy;
    ack = (we && a == 6'h30) ? wd : 32'd0;
    if (we) begin
      case (a)
        6'h00: m_txc = wd;
        6'h04: m_dma = wd;
        6'h08: m_rxc = wd;
        6'h2C: m_mask = wd;
        default: ;
      endcase
    end
    m_raw = m_raw & ~ack;
    if (fire) m_raw[3] = 1'b1;
    if (we && a == 6'h1C) m_raw[0] = 1'b1;
    if (fire) begin m_din = rd; m_dav = 1'b1; end
    else if (re && a == 6'h20) m_dav = 1'b0;
    m_txv = we && a == 6'h1C;
    if (m_txv) m_txd = wd[7:0];
    m_irq = |(m_raw & m_mask);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [5:0] addrs [14];
    addrs = '{6'h00, 6'h04, 6'h08, 6'h1C, 6'h20, 6'h24, 6'h2C, 6'h30,
              6'h34, 6'h38, 6'h0C, 6'h3C, 6'h21, 6'h10};
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values at every offset
    for (int i = 0; i < 14; i++) begin
      bus_addr = addrs[i]; #1;
      chk(bus_rdata == ((addrs[i] == 6'h20 || addrs[i] == 6'h24) ? 32'h0140_0000 : 32'd0),
          "R1", bus_rdata, model_read(addrs[i]));
    end
    chk(irq == 0 && tx_valid == 0 && rx_ready == 1, "R1", {irq, tx_valid, rx_ready}, 32'b001);

    // R2 read-back, R9 writes to read-only/unmapped ignored
    step(1, 0, 6'h00, 32'hA5A5_0F0F, 0, 0);
    step(1, 0, 6'h2C, 32'h0000_0009, 0, 0);
    step(1, 0, 6'h24, 32'hFFFF_FFFF, 0, 0);
    step(1, 0, 6'h34, 32'hFFFF_FFFF, 0, 0);
    step(1, 0, 6'h3C, 32'hFFFF_FFFF, 0, 0);
    step(0, 1, 6'h00, 0, 0, 0);
    step(0, 1, 6'h24, 0, 0, 0);
    step(0, 1, 6'h34, 0, 0, 0);
    step(0, 1, 6'h3C, 0, 0, 0);
    // R3 transmit write, R8 irq through mask bit 0
    step(1, 0, 6'h1C, 32'h1234_56C3, 0, 0);
    step(0, 1, 6'h38, 0, 0, 0);
    chk(irq == 1'b1, "R8", 32'(irq), 32'd1);
    // R4 receive, R6 non-clearing then clearing read
    step(0, 0, 6'h00, 0, 1, 8'h5E);
    step(0, 1, 6'h24, 0, 0, 0);
    chk(bus_rdata[16] && bus_rdata[7:0] == 8'h5E, "R4", bus_rdata, 32'h0141_005E);
    chk(bus_rdata[22] && bus_rdata[24], "R10", bus_rdata, 32'h0140_0000);
    step(0, 1, 6'h20, 0, 0, 0);
    step(0, 1, 6'h24, 0, 0, 0);
    chk(bus_rdata[16] == 1'b0, "R6", bus_rdata, 32'h0140_005E);
    // R5 receive blocked while bit 3 pending and rxc bit 0 clear
    step(0, 0, 6'h00, 0, 1, 8'h77);
    step(0, 1, 6'h24, 0, 0, 0);
    chk(bus_rdata[7:0] == 8'h5E, "R5", bus_rdata, 32'h0140_005E);
    // R7 ack in the same cycle as a transmit-free receive attempt; ack reads zero
    step(1, 0, 6'h30, 32'h0000_0009, 0, 0);
    step(0, 1, 6'h30, 0, 0, 0);
    step(0, 1, 6'h34, 0, 0, 0);
    step(1, 0, 6'h08, 32'h1, 0, 0);
    step(1, 0, 6'h30, 32'h8, 1, 8'h33);
    step(0, 1, 6'h34, 0, 0, 0);
    chk(bus_rdata[3] == 1'b1, "R7", bus_rdata, 32'h8);

    // random phase
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] a;
      logic [31:0] wd;
      a = addrs[$urandom % 14];
      wd = $urandom;
      if (a == 6'h30 && ($urandom % 4) != 0) wd = wd & 32'h9;
      step(($urandom % 10) < 4, ($urandom % 2) == 1, a, wd, ($urandom % 10) < 3, 8'($urandom));
    end
    step(0, 0, 6'h00, 0, 0, 0);
    finish_run();
  end
endmodule